// File: doc/BRIEF.md
# Interrupt Request Flag Bank

This block keeps the pending-request flags of an interrupt controller in three byte-wide registers placed at consecutive addresses. Each flag captures a single-cycle pulse from its source and stays set until software clears it or the controller acknowledges that request. The acknowledge arrives from outside as a flat flag index. Arbitration, masking, priority and vectoring live downstream and read the flags from a flat output vector.

The CPU side has a simple memory port. An operation code selects one of four actions: idle, whole-byte write, single-bit set or single-bit clear. The port returns the byte at the presented address, and returns the two lower registers as one 16-bit word. Single-bit operations touch only the addressed bit. A software clear therefore cannot erase a flag that hardware raised in a neighbouring bit, which can happen with a byte read-modify-write. In every cycle a hardware request takes precedence over any clear.

Top module: `irq_flag_bank`

## Requirements
- R1: While reset is asserted, all flags read 0, and they are still 0 at the first clock edge after reset is released.
- R2: A one-cycle pulse on `src_req[i]` makes `flags_o[i]` read 1 after the next clock edge. The flag stays 1 afterwards with no further pulse.
- R3: With `ack_valid` high, the flag numbered `ack_idx` reads 0 after the next edge. An index of 18 or above changes no flag.
- R4: If a source pulse and a clear of the same flag (bit clear, byte write or acknowledge) fall in the same cycle, the flag reads 1 after the edge.
- R5: `bus_op`=2 sets bit `bus_bit` of the register at `bus_addr` to 1. All other bits are unchanged.
- R6: `bus_op`=3 clears bit `bus_bit` of the addressed register. All other bits of that register keep their values.
- R7: `bus_op`=1 loads `bus_wdata` into every implemented bit of the addressed register.
- R8: The register at base+2 implements only bits 1:0. Its bits 7:2 always read 0, and byte writes or bit sets cannot change them.
- R9: `rd_data8` returns the register at `bus_addr` in the same cycle. Any address outside base..base+2 returns 0, and any operation at such an address changes no flag.
- R10: When `bus_addr` equals the base address, `rd_data16` returns {register base+1, register base}, with the base register in bits 7:0. At any other address it returns 0.
- R11: `flags_o` bit 8*k+b is bit b of the register at base+k, for 18 bits in total.
- R12: In a cycle with no operation, no acknowledge and no source pulse, no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 18 | One-cycle request pulses, one per flag |
| ack_valid | input | 1 | Acknowledge strobe from the controller |
| ack_idx | input | 5 | Flat index of the acknowledged flag |
| bus_op | input | 2 | 0 idle, 1 byte write, 2 bit set, 3 bit clear |
| bus_addr | input | 16 | Register byte address |
| bus_bit | input | 3 | Bit position for set and clear |
| bus_wdata | input | 8 | Byte write data |
| rd_data8 | output | 8 | Byte read at bus_addr |
| rd_data16 | output | 16 | Word read of the two lower registers |
| flags_o | output | 18 | Flat vector of all implemented flags |

## Verification
The bound checker checks these properties on every cycle: a source pulse wins against any clear, an acknowledge without a competing pulse clears its flag, a bit clear on the lowest register leaves its other bits alone, idle cycles hold state, and the unimplemented bits read 0. Only the bench's scenarios can show the exact values that byte writes and bit sets produce, that out-of-range acknowledges and unmapped addresses are ignored, and that the read data is ordered correctly in the byte and word views.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 3;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_BSET  = 2'd2,
        OP_BCLR  = 2'd3
    } bus_op_e;
endpackage

// File: rtl/irq_flag_decode.sv
module irq_flag_decode
    import irq_flag_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'hFFE0,
    parameter int          NUM_FLAGS = 18,
    parameter int          IDX_W     = 5
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      ack_valid,
    input  logic [IDX_W-1:0]          ack_idx,
    output logic [NUM_REGS-1:0]       sel,
    output logic [NUM_REGS*REG_W-1:0] ack_clr
);
    localparam int PAD_W = NUM_REGS * REG_W;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
        assign sel[r] = (addr == ADDR_W'(BASE_ADDR + 16'(r)));
    end

    for (genvar k = 0; k < PAD_W; k++) begin : g_ack
        if (k < NUM_FLAGS) begin : g_impl
            assign ack_clr[k] = ack_valid && (ack_idx == IDX_W'(k));
        end else begin : g_none
            assign ack_clr[k] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import irq_flag_pkg::*;
#(
    parameter int W    = 8,
    parameter int IMPL = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic [1:0]           op,
    input  logic [$clog2(W)-1:0] pos,
    input  logic [W-1:0]         wdata,
    input  logic [W-1:0]         hw_set,
    input  logic [W-1:0]         ack_clr,
    output logic [W-1:0]         q
);
    localparam logic [W-1:0] MASK = {W{1'b1}} >> (W - IMPL);

    typedef struct packed {
        logic [W-1:0] flags;
    } reg_state_t;

    reg_state_t state_d, state_q;
    bus_op_e    op_e;

    assign op_e = bus_op_e'(op);

    always_comb begin
        state_d = state_q;
        if (sel) begin
            case (op_e)
                OP_WRITE: state_d.flags = wdata;
                OP_BSET:  state_d.flags[pos] = 1'b1;
                OP_BCLR:  state_d.flags[pos] = 1'b0;
                default:  ;
            endcase
        end
        state_d.flags = state_d.flags & ~ack_clr;
        state_d.flags = state_d.flags | hw_set;
        state_d.flags = state_d.flags & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q = state_q.flags;
endmodule

// File: rtl/irq_flag_rdmux.sv
module irq_flag_rdmux
    import irq_flag_pkg::*;
(
    input  logic [NUM_REGS*REG_W-1:0] regs_flat,
    input  logic [NUM_REGS-1:0]       sel,
    output logic [REG_W-1:0]          rd8,
    output logic [2*REG_W-1:0]        rd16
);
    always_comb begin
        rd8 = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (sel[r]) rd8 = rd8 | regs_flat[r*REG_W +: REG_W];
        end
        rd16 = sel[0] ? regs_flat[2*REG_W-1:0] : '0;
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_flag_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'hFFE0,
    parameter int          HI_IMPL   = 2,
    localparam int         NUM_FLAGS = (NUM_REGS - 1) * REG_W + HI_IMPL,
    localparam int         IDX_W     = $clog2(NUM_FLAGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] src_req,
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_idx,
    input  logic [1:0]           bus_op,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [2:0]           bus_bit,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     rd_data8,
    output logic [2*REG_W-1:0]   rd_data16,
    output logic [NUM_FLAGS-1:0] flags_o
);
    localparam int PAD_W = NUM_REGS * REG_W;

    logic [NUM_REGS-1:0] sel;
    logic [PAD_W-1:0]    ack_clr;
    logic [PAD_W-1:0]    src_pad;
    logic [PAD_W-1:0]    regs_flat;

    assign src_pad = PAD_W'(src_req);

    irq_flag_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .NUM_FLAGS (NUM_FLAGS),
        .IDX_W     (IDX_W)
    ) u_decode (
        .addr      (bus_addr),
        .ack_valid (ack_valid),
        .ack_idx   (ack_idx),
        .sel       (sel),
        .ack_clr   (ack_clr)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        localparam int IMPL = (r == NUM_REGS - 1) ? HI_IMPL : REG_W;
        irq_flag_reg #(
            .W    (REG_W),
            .IMPL (IMPL)
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (sel[r]),
            .op      (bus_op),
            .pos     (bus_bit),
            .wdata   (bus_wdata),
            .hw_set  (src_pad[r*REG_W +: REG_W]),
            .ack_clr (ack_clr[r*REG_W +: REG_W]),
            .q       (regs_flat[r*REG_W +: REG_W])
        );
    end

    irq_flag_rdmux u_rdmux (
        .regs_flat (regs_flat),
        .sel       (sel),
        .rd8       (rd_data8),
        .rd16      (rd_data16)
    );

    assign flags_o = regs_flat[NUM_FLAGS-1:0];
endmodule

// File: rtl/irq_flag_bank_chk.sv
module irq_flag_bank_chk #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'hFFE0,
    parameter int          HI_IMPL   = 2,
    parameter int          NUM_FLAGS = 18,
    parameter int          IDX_W     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_FLAGS-1:0] src_req,
    input logic                 ack_valid,
    input logic [IDX_W-1:0]     ack_idx,
    input logic [1:0]           bus_op,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [2:0]           bus_bit,
    input logic [7:0]           rd_data8,
    input logic [NUM_FLAGS-1:0] flags_o
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (flags_o == '0)); // R1

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_bit
        AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            src_req[i] |=> flags_o[i]); // R4

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_valid && ack_idx == IDX_W'(i) && !src_req[i]) |=> !flags_o[i]); // R3
    end

    AST_BITCLR_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op == 2'd3 && bus_addr == ADDR_W'(BASE_ADDR) && !ack_valid && src_req == '0)
        |=> (flags_o[7:0] == ($past(flags_o[7:0]) & ~(8'd1 << $past(bus_bit))))); // R6

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(BASE_ADDR + 16'd2)) |-> ((rd_data8 >> HI_IMPL) == 8'd0)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op == 2'd0 && !ack_valid && src_req == '0) |=> $stable(flags_o)); // R12
endmodule

bind irq_flag_bank irq_flag_bank_chk #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .HI_IMPL   (HI_IMPL),
    .NUM_FLAGS (NUM_FLAGS),
    .IDX_W     (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .bus_op    (bus_op),
    .bus_addr  (bus_addr),
    .bus_bit   (bus_bit),
    .rd_data8  (rd_data8),
    .flags_o   (flags_o)
);

// File: tb/irq_flag_bank_tb.sv
module irq_flag_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] src_req = '0;
    logic        ack_valid = 1'b0;
    logic [4:0]  ack_idx = '0;
    logic [1:0]  bus_op = '0;
    logic [15:0] bus_addr = 16'h0000;
    logic [2:0]  bus_bit = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  rd_data8;
    logic [15:0] rd_data16;
    logic [17:0] flags_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .ack_valid (ack_valid),
        .ack_idx   (ack_idx),
        .bus_op    (bus_op),
        .bus_addr  (bus_addr),
        .bus_bit   (bus_bit),
        .bus_wdata (bus_wdata),
        .rd_data8  (rd_data8),
        .rd_data16 (rd_data16),
        .flags_o   (flags_o)
    );

    // tag[74:71] op[70:69] addr[68:53] bit[52:50] wdata[49:42] src[41:24] ackv[23] acki[22:18] exp[17:0]
    localparam logic [74:0] VECS [NV] = '{
        {4'd7,  2'd1, 16'hFFE0, 3'd0, 8'hA5, 18'h00000, 1'b0, 5'd0,  18'h000A5}, // R7 byte write
        {4'd5,  2'd2, 16'hFFE1, 3'd3, 8'h00, 18'h00000, 1'b0, 5'd0,  18'h008A5}, // R5 bit set
        {4'd6,  2'd3, 16'hFFE0, 3'd0, 8'h00, 18'h00002, 1'b0, 5'd0,  18'h008A6}, // R6 and R2
        {4'd3,  2'd0, 16'h0000, 3'd0, 8'h00, 18'h00000, 1'b1, 5'd11, 18'h000A6}, // R3 ack
        {4'd8,  2'd1, 16'hFFE2, 3'd0, 8'hFF, 18'h00000, 1'b0, 5'd0,  18'h300A6}, // R8 masked write
        {4'd4,  2'd0, 16'h0000, 3'd0, 8'h00, 18'h20000, 1'b1, 5'd17, 18'h300A6}, // R4 set beats ack
        {4'd4,  2'd1, 16'hFFE1, 3'd0, 8'h00, 18'h00200, 1'b0, 5'd0,  18'h302A6}, // R4 set beats write
        {4'd3,  2'd0, 16'h0000, 3'd0, 8'h00, 18'h00000, 1'b1, 5'd20, 18'h302A6}, // R3 out of range
        {4'd8,  2'd2, 16'hFFE2, 3'd5, 8'h00, 18'h00000, 1'b0, 5'd0,  18'h302A6}, // R8 bit set ignored
        {4'd9,  2'd1, 16'hFFE3, 3'd0, 8'hFF, 18'h00000, 1'b0, 5'd0,  18'h302A6}, // R9 unmapped write
        {4'd6,  2'd3, 16'hFFE0, 3'd7, 8'h00, 18'h00000, 1'b0, 5'd0,  18'h30226}, // R6 clear bit 7
        {4'd12, 2'd0, 16'h0000, 3'd0, 8'h00, 18'h00000, 1'b0, 5'd0,  18'h30226}  // R12 idle; R11 layout
    };

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        src_req = '0; ack_valid = 1'b0; ack_idx = '0;
        bus_op = 2'd0; bus_addr = 16'h0000; bus_bit = '0; bus_wdata = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", flags_o, 18'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [74:0] e;
            e = VECS[v];
            bus_op    = e[70:69];
            bus_addr  = e[68:53];
            bus_bit   = e[52:50];
            bus_wdata = e[49:42];
            src_req   = e[41:24];
            ack_valid = e[23];
            ack_idx   = e[22:18];
            @(negedge clk);
            idle_inputs();
            check($sformatf("R%0d vector %0d", e[74:71], v), flags_o, e[17:0]);
        end

        // R9 byte reads and unmapped address; R10 word read
        bus_addr = 16'hFFE0; #1;
        check("R9 read base", 18'(rd_data8), 18'h26);
        check("R10 word read", 18'(rd_data16), 18'h0226);
        bus_addr = 16'hFFE1; #1;
        check("R9 read base+1", 18'(rd_data8), 18'h02);
        check("R10 word off base", 18'(rd_data16), 18'h0);
        bus_addr = 16'hFFE2; #1;
        check("R8 read base+2", 18'(rd_data8), 18'h03);
        bus_addr = 16'hFFE3; #1;
        check("R9 unmapped read", 18'(rd_data8), 18'h0);
        bus_addr = 16'h0000;

        // R2 a flag set by a pulse stays set without further pulses
        @(negedge clk);
        src_req = 18'h00010;
        @(negedge clk);
        src_req = '0;
        repeat (3) @(negedge clk);
        check("R2 pulse held", flags_o, 18'h30236);

        // R1 reset during operation
        rst_n = 1'b0;
        #1;
        check("R1 async reset", flags_o, 18'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", flags_o, 18'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule